// File: doc/BRIEF.md
# Wake-Up Cause Capture Register

This block records why a device left its low-power state. Up to sixteen wake-up pins, two alarm timers (a calendar alarm and a tick-timer alarm), a 3.3 V supply monitor, a force-wake pin and a slow-crystal frequency checker each deliver single-cycle event pulses. These pulses are already synchronized. Every event sets a sticky flag in one 32-bit status word. A per-pin mode input sends pin wake-ups that go through tamper or debounce detection to a separate status register, which lives outside this block. For those pins this word records only the summary pin flag.

Software reads the word through a request/response port. The read is accepted on one clock edge, and on that same edge the block copies the word into the response register and clears exactly the flags it copied. An event that arrives during the accepting cycle is not part of that response. It stays set and appears in the next read. The request side accepts when `req_valid && req_ready`. `req_ready` is high whenever the response register is empty or is being drained in the same cycle (`!rsp_valid || rsp_ready`). A response stays valid and unchanged until `rsp_ready` is seen high.

Top module: `wake_cause_reg`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every flag is 0, so the first read at the register offset returns 0x00000000.
- R2: Field layout: pin i sets bit 16+i; bit 5 is the calendar alarm; bit 4 is the tick-timer alarm; bit 3 is the supply-monitor wake-up; bit 2 is the force-wake pin; bit 1 is the crystal frequency error; bit 8 is the supply-monitor core reset. Bits 7:6 and 15:9 always read 0, as do pin bits at and above 16+NUM_PINS.
- R3: Each flag is sticky. Any number of its events between two reads give a single 1, which holds until a read at the register offset is accepted.
- R4: An accepted read at the register offset clears every flag it returned, so an immediate second read returns 0.
- R5: An event arriving in the same cycle as an accepted read is absent from that response, and its flag is set in the following read.
- R6: Bit 0 (pin summary) is set by an event on any pin, whether or not that pin is in tamper/debounce mode.
- R7: A pin whose tamper/debounce mode input is 1 during its event does not set its own bit 16+i.
- R8: A supply-monitor wake-up event sets bit 3 only while `smon_sample_cfg` is nonzero.
- R9: A read at any address other than REG_OFFSET (default 0x24) returns 0 and clears no flag.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid && !rsp_ready`, `rsp_valid` stays 1 and `rsp_data` stays stable, and events keep being captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_evt | input | NUM_PINS | Per-pin wake-up event pulses |
| pin_tamper_mode | input | NUM_PINS | 1 = pin is in tamper/debounce mode |
| rtc_evt | input | 1 | Calendar alarm wake-up pulse |
| rtt_evt | input | 1 | Tick-timer alarm wake-up pulse |
| smon_evt | input | 1 | Supply-monitor wake-up pulse |
| smon_sample_cfg | input | SMPL_W | Supply-monitor sampling setting; 0 disables bit 3 |
| fwup_evt | input | 1 | Force-wake pin pulse |
| xtal_err_evt | input | 1 | Slow-crystal frequency error pulse |
| smon_rst_evt | input | 1 | Core reset by supply monitor pulse |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with req_valid |
| req_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | Response data valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Returned status word |

## Verification
The bench builds the block with its defaults: NUM_PINS=16, SMPL_W=4, ADDR_W=8 and REG_OFFSET=0x24. With these values the top pin bit 31 is reachable, so the full upper half of the word can be checked for placement and tamper suppression. The bench also reaches a non-matching address next to the offset and a zero and a nonzero sampling setting. Because the response register can be stalled, the read/event race can be driven on the exact accepting edge, and so can events that arrive while a response is held.

// File: rtl/wkc_pkg.sv
package wkc_pkg;
  localparam int WORD_W    = 32;
  localparam int BIT_SUM   = 0;
  localparam int BIT_XTAL  = 1;
  localparam int BIT_FWUP  = 2;
  localparam int BIT_SMON  = 3;
  localparam int BIT_RTT   = 4;
  localparam int BIT_RTC   = 5;
  localparam int BIT_SMRST = 8;
  localparam int PIN_BASE  = 16;
  localparam int PIN_MAX   = 16;

  // non-pin sources, one sticky bit each
  typedef struct packed {
    logic smrst;
    logic rtc;
    logic rtt;
    logic smon;
    logic fwup;
    logic xtal;
  } src_vec_t;

  localparam int SRC_W = $bits(src_vec_t);
endpackage

// File: rtl/wkc_sticky_bank.sv
module wkc_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set wins over clear so a racing event survives the read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/wkc_pin_capture.sv
module wkc_pin_capture #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_evt,
  input  logic [NUM_PINS-1:0] pin_tamper_mode,
  input  logic [NUM_PINS-1:0] clr_pins,
  input  logic                clr_sum,
  output logic [NUM_PINS-1:0] pin_flags,
  output logic                sum_flag
);
  localparam int BW = NUM_PINS + 1;

  logic [BW-1:0] set_v, clr_v, q_v;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // tamper/debounce pins report elsewhere
    assign set_v[i+1] = pin_evt[i] & ~pin_tamper_mode[i];
    assign clr_v[i+1] = clr_pins[i];
  end

  assign set_v[0] = |pin_evt;
  assign clr_v[0] = clr_sum;

  wkc_sticky_bank #(.W(BW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (q_v)
  );

  assign pin_flags = q_v[BW-1:1];
  assign sum_flag  = q_v[0];
endmodule

// File: rtl/wkc_src_capture.sv
module wkc_src_capture
  import wkc_pkg::*;
#(
  parameter int SMPL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_vec_t          src_evt,
  input  logic [SMPL_W-1:0] smon_sample_cfg,
  input  src_vec_t          src_clr,
  output src_vec_t          src_flags
);
  src_vec_t set_v;
  logic     smon_on;
  logic [SRC_W-1:0] q_v;

  assign smon_on = |smon_sample_cfg;

  always_comb begin
    set_v      = src_evt;
    set_v.smon = src_evt.smon & smon_on;
  end

  wkc_sticky_bank #(.W(SRC_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (src_clr),
    .q_o   (q_v)
  );

  assign src_flags = src_vec_t'(q_v);
endmodule

// File: rtl/wkc_read_port.sv
module wkc_read_port #(
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h24,
  parameter int          DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] clr_o,
  output logic              take_o
);
  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  logic              take, hit;

  assign req_ready = !vld_q || rsp_ready;
  assign take      = req_valid && req_ready;
  assign hit       = (req_addr == REG_OFFSET);

  // only what is copied into the response is cleared
  assign clr_o  = (take && hit) ? word_i : '0;
  assign take_o = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      data_q <= hit ? word_i : '0;
    end else if (rsp_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;
endmodule

// File: rtl/wake_cause_reg.sv
module wake_cause_reg
  import wkc_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int SMPL_W   = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_evt,
  input  logic [NUM_PINS-1:0] pin_tamper_mode,
  input  logic                rtc_evt,
  input  logic                rtt_evt,
  input  logic                smon_evt,
  input  logic [SMPL_W-1:0]   smon_sample_cfg,
  input  logic                fwup_evt,
  input  logic                xtal_err_evt,
  input  logic                smon_rst_evt,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORD_W-1:0]   rsp_data
);
  logic [NUM_PINS-1:0] pin_flags;
  logic                sum_flag;
  src_vec_t            src_evt, src_clr, src_flags;
  logic [WORD_W-1:0]   status_word, clr_word;
  logic                rd_take;

  assign src_evt = '{smrst: smon_rst_evt, rtc: rtc_evt, rtt: rtt_evt,
                     smon: smon_evt, fwup: fwup_evt, xtal: xtal_err_evt};

  wkc_pin_capture #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk             (clk),
    .rst_n           (rst_n),
    .pin_evt         (pin_evt),
    .pin_tamper_mode (pin_tamper_mode),
    .clr_pins        (clr_word[PIN_BASE +: NUM_PINS]),
    .clr_sum         (clr_word[BIT_SUM]),
    .pin_flags       (pin_flags),
    .sum_flag        (sum_flag)
  );

  wkc_src_capture #(.SMPL_W(SMPL_W)) u_src (
    .clk             (clk),
    .rst_n           (rst_n),
    .src_evt         (src_evt),
    .smon_sample_cfg (smon_sample_cfg),
    .src_clr         (src_clr),
    .src_flags       (src_flags)
  );

  always_comb begin
    src_clr       = '0;
    src_clr.xtal  = clr_word[BIT_XTAL];
    src_clr.fwup  = clr_word[BIT_FWUP];
    src_clr.smon  = clr_word[BIT_SMON];
    src_clr.rtt   = clr_word[BIT_RTT];
    src_clr.rtc   = clr_word[BIT_RTC];
    src_clr.smrst = clr_word[BIT_SMRST];
  end

  // word assembly; unlisted positions stay zero
  always_comb begin
    status_word                        = '0;
    status_word[BIT_SUM]               = sum_flag;
    status_word[BIT_XTAL]              = src_flags.xtal;
    status_word[BIT_FWUP]              = src_flags.fwup;
    status_word[BIT_SMON]              = src_flags.smon;
    status_word[BIT_RTT]               = src_flags.rtt;
    status_word[BIT_RTC]               = src_flags.rtc;
    status_word[BIT_SMRST]             = src_flags.smrst;
    status_word[PIN_BASE +: NUM_PINS]  = pin_flags;
  end

  wkc_read_port #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET),
    .DATA_W     (WORD_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .word_i    (status_word),
    .clr_o     (clr_word),
    .take_o    (rd_take)
  );
endmodule

// File: rtl/wkc_checker.sv
module wkc_checker #(
  parameter int NUM_PINS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [31:0]         flags,
  input logic                take,
  input logic [NUM_PINS-1:0] pin_evt,
  input logic [NUM_PINS-1:0] pin_tamper_mode,
  input logic                rtc_evt,
  input logic                smon_gate,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [31:0]         rsp_data
);
  always_comb begin
    if (rst_n) begin
      assert_reserved_zero_R2: assert (flags[15:9] == 7'd0 && flags[7:6] == 2'd0)
        else $error("reserved status bits set");
    end
  end

  // R3: no flag drops without an accepted read
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ((flags & $past(flags)) == $past(flags)));

  // R5: event on the read edge survives the clear
  assert_race_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rtc_evt) |=> flags[5]);

  assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_evt) |=> flags[0]);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_tmp
    assert_tamper_hide_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_evt[i] && pin_tamper_mode[i] && !flags[16+i]) |=> !flags[16+i]);
  end

  assert_smon_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!smon_gate && !flags[3]) |=> !flags[3]);

  assert_ready_rule_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));

  assert_hold_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind wake_cause_reg wkc_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .flags           (status_word),
  .take            (rd_take),
  .pin_evt         (pin_evt),
  .pin_tamper_mode (pin_tamper_mode),
  .rtc_evt         (rtc_evt),
  .smon_gate       (|smon_sample_cfg),
  .req_ready       (req_ready),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_data        (rsp_data)
);

// File: tb/sim_wake_cause_reg.sv
module sim_wake_cause_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_evt = '0, pin_tamper_mode = '0;
  logic        rtc_evt = 0, rtt_evt = 0, smon_evt = 0, fwup_evt = 0;
  logic        xtal_err_evt = 0, smon_rst_evt = 0;
  logic [3:0]  smon_sample_cfg = 4'd1;
  logic        req_valid = 0, rsp_ready = 1;
  logic [7:0]  req_addr = 8'h24;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wake_cause_reg u0 (
    .clk(clk), .rst_n(rst_n), .pin_evt(pin_evt), .pin_tamper_mode(pin_tamper_mode),
    .rtc_evt(rtc_evt), .rtt_evt(rtt_evt), .smon_evt(smon_evt),
    .smon_sample_cfg(smon_sample_cfg), .fwup_evt(fwup_evt),
    .xtal_err_evt(xtal_err_evt), .smon_rst_evt(smon_rst_evt),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one read with rsp_ready high; returns the data seen after the accept edge
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0; d = rsp_data;
    check("R10 rsp_valid after accept", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic pulse(input logic [15:0] pins, input logic [5:0] src);
    @(negedge clk);
    pin_evt = pins;
    {smon_rst_evt, rtc_evt, rtt_evt, smon_evt, fwup_evt, xtal_err_evt} = src;
    @(negedge clk);
    pin_evt = '0;
    {smon_rst_evt, rtc_evt, rtt_evt, smon_evt, fwup_evt, xtal_err_evt} = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rsp_valid at reset", {31'd0, rsp_valid}, 32'd0);
    rd(8'h24, d);
    check("R1 first read", d, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    pulse(16'h8001, 6'b000000); rd(8'h24, d);
    check("R2 pins 0 and 15", d, 32'h8001_0001);
    pulse(16'h0000, 6'b010000); rd(8'h24, d); check("R2 rtc bit5", d, 32'h20);
    pulse(16'h0000, 6'b001000); rd(8'h24, d); check("R2 rtt bit4", d, 32'h10);
    pulse(16'h0000, 6'b000100); rd(8'h24, d); check("R2 smon bit3", d, 32'h08);
    pulse(16'h0000, 6'b000010); rd(8'h24, d); check("R2 fwup bit2", d, 32'h04);
    pulse(16'h0000, 6'b000001); rd(8'h24, d); check("R2 xtal bit1", d, 32'h02);
    pulse(16'h0000, 6'b100000); rd(8'h24, d); check("R2 smrst bit8", d, 32'h100);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(16'h0010, 6'b010000);
    pulse(16'h0010, 6'b010000);
    pulse(16'h0200, 6'b000000);
    repeat (5) @(negedge clk);
    rd(8'h24, d);
    check("R3 merged events", d, 32'h0210_0021);
    rd(8'h24, d);
    check("R4 back-to-back read clear", d, 32'h0);
    rd(8'h24, d);
    check("R4 third read still zero", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(16'h0004, 6'b000000);
    @(negedge clk);
    req_valid = 1; req_addr = 8'h24; rtc_evt = 1; pin_evt = 16'h0002;
    @(negedge clk);
    req_valid = 0; rtc_evt = 0; pin_evt = '0;
    check("R5 racing read excludes new events", rsp_data, 32'h0004_0001);
    rd(8'h24, d);
    check("R5 racing events survive", d, 32'h0002_0021);
  endtask

  task automatic t_tamper();
    logic [31:0] d;
    pin_tamper_mode = 16'h0081;
    pulse(16'h0083, 6'b000000);
    rd(8'h24, d);
    check("R7 tamper pins hidden, R6 summary set", d, 32'h0002_0001);
    pulse(16'h0001, 6'b000000);
    rd(8'h24, d);
    check("R6 summary from tamper-only pin", d, 32'h0000_0001);
    pin_tamper_mode = '0;
  endtask

  task automatic t_smon();
    logic [31:0] d;
    smon_sample_cfg = 4'd0;
    pulse(16'h0000, 6'b000100);
    rd(8'h24, d);
    check("R8 smon gated off", d, 32'h0);
    smon_sample_cfg = 4'd9;
    pulse(16'h0000, 6'b000100);
    rd(8'h24, d);
    check("R8 smon with nonzero setting", d, 32'h08);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    pulse(16'h0040, 6'b001000);
    rd(8'h20, d);
    check("R9 other address reads zero", d, 32'h0);
    rd(8'h24, d);
    check("R9 flags kept after other address", d, 32'h0040_0011);
  endtask

  task automatic t_stall();
    logic [31:0] d;
    pulse(16'h0000, 6'b000010);
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_addr = 8'h24;
    @(negedge clk);
    check("R10 held data", rsp_data, 32'h04);
    check("R10 req_ready low while held", {31'd0, req_ready}, 32'd0);
    xtal_err_evt = 1;
    @(negedge clk); xtal_err_evt = 0;
    repeat (2) @(negedge clk);
    check("R10 data stable", rsp_data, 32'h04);
    check("R10 valid kept", {31'd0, rsp_valid}, 32'd1);
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    check("R10 drains", {31'd0, rsp_valid}, 32'd0);
    rd(8'h24, d);
    check("R10 event during stall captured", d, 32'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_layout();
    t_sticky();
    t_race();
    t_tamper();
    t_smon();
    t_addr();
    t_stall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule